// File: doc/BRIEF.md
# Self-Test Sequencer with Four-Bit Pattern Generator

This block runs a self-test on an attached circuit under test (CUT). While idle it passes functional data straight to the CUT inputs and takes a four-bit seed one bit per cycle from a serial input. A start pulse begins the test. The block loads the seed into a four-bit shift-register pattern generator and clears the external signature compressor for one cycle. It then switches the CUT input multiplexer over to the generator output for a fixed number of pattern cycles.

After the last pattern, the block compares the compressor's signature with a golden value that arrives on an input. It reports the outcome on a single serial status pin while its done flag is high. The CUT and the signature compressor sit outside the block and connect through ports. The golden signature is supplied by the user.

Top module: `bist_engine`

## Requirements
- R1: After a synchronous reset the block is idle: `done`, `ser_out`, `bist_sel`, `sig_clr` and `sig_en` are all 0.
- R2: In every cycle where `bist_sel` is 0, `cut_in` equals `func_in`.
- R3: While idle with `start` low, `ser_in` is shifted in MSB first, and the last four bits form the seed. A `start` pulse while idle produces exactly one cycle with `sig_clr` high, and pattern cycles follow immediately after it.
- R4: An all-zero seed is replaced by 1000 (bit 3 down to bit 0). The generator never holds the all-zero value while patterns are applied.
- R5: Each generator step shifts one place toward bit 3. The old bit 3 enters bit 0 and is also XORed into the value entering bit 1. From 1000 the patterns are 8,3,6,C,B,5,A,7,E,F,D,9,1,2,4 (hex).
- R6: The test applies exactly 15 patterns. `bist_sel` and `sig_en` are high in exactly those cycles, and `cut_in` carries the current pattern, the first pattern being the seed.
- R7: In the single cycle after the last pattern, `sig_in` is compared with `golden`. The status bit is 1 when they are equal and 0 otherwise.
- R8: The compare cycle is followed by two cycles with `done` high. `ser_out` carries a marker 1 in the first of them and the status bit in the second. Outside these two cycles `ser_out` is 0, and then the block returns to idle.
- R9: `start` has no effect outside the idle state: a pulse during a test changes neither the pattern count nor the timing of `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a self-test (idle only) |
| ser_in | input | 1 | Serial seed bits, MSB first |
| ser_out | output | 1 | Serial status: marker then pass bit |
| done | output | 1 | High during the two status cycles |
| func_in | input | 4 | Functional data for the CUT |
| cut_in | output | 4 | Multiplexed CUT input |
| bist_sel | output | 1 | High while test patterns drive the CUT |
| sig_clr | output | 1 | Clears the external signature compressor |
| sig_en | output | 1 | Enables compression of CUT responses |
| sig_in | input | 4 | Signature from the external compressor |
| golden | input | 4 | Expected signature |

## Verification
The generator is run from the power-up seed 1000 and checked against the full listed cycle, which separates a correct feedback tap from any other. Runs from a mid-cycle seed (0110) and from an all-zero seed check, respectively, that seed loading is bit-exact and that the zero seed is substituted. A matching and a deliberately wrong golden value show that the status bit follows the comparison and is not fixed. A start pulse injected in the middle of a run separates a controller that ignores it from one that restarts.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEED = 3'd1,
    ST_RUN  = 3'd2,
    ST_CMP  = 3'd3,
    ST_DONE = 3'd4
  } bist_state_e;

  // status frame: marker bit followed by the pass bit
  localparam int STAT_BITS = 2;

endpackage

// File: rtl/bist_lfsr_gen.sv
module bist_lfsr_gen #(
  parameter int         W            = 4,
  parameter logic [W-1:0] TAPS       = 4'b0011,
  parameter logic [W-1:0] START_SEED = 4'b1000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] seed,
  output logic [W-1:0] pat
);

  logic [W-1:0] nxt;
  logic [W-1:0] seed_eff;
  logic         fb;

  assign fb       = pat[W-1];
  assign seed_eff = (seed == '0) ? START_SEED : seed;

  // internal-XOR feedback, one bit per generate slice
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign nxt[i] = TAPS[i] & fb;
    end else begin : g_upper
      assign nxt[i] = pat[i-1] ^ (TAPS[i] & fb);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pat <= START_SEED;
    end else if (load) begin
      pat <= seed_eff;
    end else if (step) begin
      pat <= nxt;
    end
  end

endmodule

// File: rtl/bist_seq_ctrl.sv
module bist_seq_ctrl
  import bist_pkg::*;
#(
  parameter int NPAT     = 15,
  parameter int HOLD_CYC = STAT_BITS
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output bist_state_e state,
  output logic        load_seed,
  output logic        step,
  output logic        cmp_now,
  output logic        in_done
);

  localparam int CNT_MAX = (NPAT > HOLD_CYC) ? NPAT : HOLD_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_SEED;
        end
        ST_SEED: begin
          cnt   <= '0;
          state <= ST_RUN;
        end
        ST_RUN: begin
          if (cnt == CNT_W'(NPAT - 1)) begin
            cnt   <= '0;
            state <= ST_CMP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CMP: begin
          cnt   <= '0;
          state <= ST_DONE;
        end
        ST_DONE: begin
          if (cnt == CNT_W'(HOLD_CYC - 1)) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          cnt   <= '0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign load_seed = (state == ST_SEED);
  assign step      = (state == ST_RUN);
  assign cmp_now   = (state == ST_CMP);
  assign in_done   = (state == ST_DONE);

endmodule

// File: rtl/bist_serial_port.sv
module bist_serial_port
  import bist_pkg::*;
#(
  parameter int SEED_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_seed,
  input  logic              ser_in,
  input  logic              load_stat,
  input  logic              pass,
  input  logic              shift_stat,
  output logic [SEED_W-1:0] seed,
  output logic              ser_out
);

  logic [STAT_BITS-1:0] stat_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      seed <= '0;
    end else if (shift_seed) begin
      seed <= {seed[SEED_W-2:0], ser_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_sr <= '0;
    end else if (load_stat) begin
      stat_sr <= {1'b1, pass};
    end else if (shift_stat) begin
      stat_sr <= {stat_sr[STAT_BITS-2:0], 1'b0};
    end
  end

  assign ser_out = shift_stat & stat_sr[STAT_BITS-1];

endmodule

// File: rtl/bist_input_mux.sv
module bist_input_mux #(
  parameter int W = 4
) (
  input  logic         sel,
  input  logic [W-1:0] func_d,
  input  logic [W-1:0] test_d,
  output logic [W-1:0] y
);

  assign y = sel ? test_d : func_d;

endmodule

// File: rtl/bist_engine.sv
module bist_engine
  import bist_pkg::*;
#(
  parameter int           W          = 4,
  parameter int           SIG_W      = 4,
  parameter int           NPAT       = 15,
  parameter logic [W-1:0] TAPS       = 4'b0011,
  parameter logic [W-1:0] START_SEED = 4'b1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             done,
  input  logic [W-1:0]     func_in,
  output logic [W-1:0]     cut_in,
  output logic             bist_sel,
  output logic             sig_clr,
  output logic             sig_en,
  input  logic [SIG_W-1:0] sig_in,
  input  logic [SIG_W-1:0] golden
);

  bist_state_e  state;
  logic         load_seed;
  logic         step;
  logic         cmp_now;
  logic         in_done;
  logic [W-1:0] seed;
  logic [W-1:0] pat;
  logic         sig_match;

  bist_seq_ctrl #(
    .NPAT     (NPAT),
    .HOLD_CYC (STAT_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .state     (state),
    .load_seed (load_seed),
    .step      (step),
    .cmp_now   (cmp_now),
    .in_done   (in_done)
  );

  bist_lfsr_gen #(
    .W          (W),
    .TAPS       (TAPS),
    .START_SEED (START_SEED)
  ) u_gen (
    .clk  (clk),
    .rst  (rst),
    .load (load_seed),
    .step (step),
    .seed (seed),
    .pat  (pat)
  );

  assign sig_match = (sig_in == golden);

  bist_serial_port #(
    .SEED_W (W)
  ) u_port (
    .clk        (clk),
    .rst        (rst),
    .shift_seed ((state == ST_IDLE) && !start),
    .ser_in     (ser_in),
    .load_stat  (cmp_now),
    .pass       (sig_match),
    .shift_stat (in_done),
    .seed       (seed),
    .ser_out    (ser_out)
  );

  bist_input_mux #(
    .W (W)
  ) u_mux (
    .sel    (step),
    .func_d (func_in),
    .test_d (pat),
    .y      (cut_in)
  );

  assign bist_sel = step;
  assign sig_en   = step;
  assign sig_clr  = load_seed;
  assign done     = in_done;

endmodule

// File: rtl/bist_engine_chk.sv
module bist_engine_chk #(
  parameter int           W    = 4,
  parameter int           NPAT = 15,
  parameter logic [W-1:0] TAPS = 4'b0011
) (
  input logic         clk,
  input logic         rst,
  input logic         done,
  input logic         ser_out,
  input logic         bist_sel,
  input logic         sig_clr,
  input logic         sig_en,
  input logic [W-1:0] cut_in,
  input logic [W-1:0] func_in
);

  localparam int LEN_W = $clog2(NPAT + 2);

  logic [LEN_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
    end else if (bist_sel) begin
      run_len <= run_len + 1'b1;
    end else if (sig_clr) begin
      run_len <= '0;
    end
  end

  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!done && !bist_sel && !ser_out && !sig_clr));

  // R2
  a_r2_func_pass: assert property (@(posedge clk) disable iff (rst)
    !bist_sel |-> (cut_in == func_in));

  // R3
  a_r3_clear_then_run: assert property (@(posedge clk) disable iff (rst)
    sig_clr |=> (bist_sel && !sig_clr));

  // R4
  a_r4_never_zero: assert property (@(posedge clk) disable iff (rst)
    bist_sel |-> (cut_in != '0));

  // R5
  a_r5_step_rule: assert property (@(posedge clk) disable iff (rst)
    (bist_sel && $past(bist_sel)) |->
      (cut_in == (({$past(cut_in[W-2:0]), 1'b0}) ^ ({W{$past(cut_in[W-1])}} & TAPS))));

  // R6
  a_r6_run_length: assert property (@(posedge clk) disable iff (rst)
    $fell(bist_sel) |-> (run_len == LEN_W'(NPAT)));

  // R6
  a_r6_en_with_sel: assert property (@(posedge clk) disable iff (rst)
    sig_en == bist_sel);

  // R8
  a_r8_done_two: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |=> done);

  // R8
  a_r8_done_ends: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |=> !done);

  // R8
  a_r8_quiet_out: assert property (@(posedge clk) disable iff (rst)
    !done |-> !ser_out);

  // R8
  a_r8_marker: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ser_out);

endmodule

bind bist_engine bist_engine_chk #(
  .W    (W),
  .NPAT (NPAT),
  .TAPS (TAPS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .done     (done),
  .ser_out  (ser_out),
  .bist_sel (bist_sel),
  .sig_clr  (sig_clr),
  .sig_en   (sig_en),
  .cut_in   (cut_in),
  .func_in  (func_in)
);

// File: tb/test_bist_engine.sv
module test_bist_engine;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic       ser_in;
  logic       ser_out;
  logic       done;
  logic [3:0] func_in;
  logic [3:0] cut_in;
  logic       bist_sel;
  logic       sig_clr;
  logic       sig_en;
  logic [3:0] sig_in;
  logic [3:0] golden;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bist_engine i_bist_engine (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .ser_in   (ser_in),
    .ser_out  (ser_out),
    .done     (done),
    .func_in  (func_in),
    .cut_in   (cut_in),
    .bist_sel (bist_sel),
    .sig_clr  (sig_clr),
    .sig_en   (sig_en),
    .sig_in   (sig_in),
    .golden   (golden)
  );

  // bench-side CUT plus signature compressor
  logic [3:0] comp_sig;
  always_ff @(posedge clk) begin
    if (rst || sig_clr) comp_sig <= '0;
    else if (sig_en)    comp_sig <= {comp_sig[2:0], comp_sig[3]} ^ (cut_in ^ 4'h5);
  end
  assign sig_in = comp_sig;

  logic [3:0] ref_seq [15] = '{4'h8, 4'h3, 4'h6, 4'hC, 4'hB, 4'h5, 4'hA, 4'h7,
                               4'hE, 4'hF, 4'hD, 4'h9, 4'h1, 4'h2, 4'h4};

  function automatic logic [3:0] nstep(input logic [3:0] p);
    logic [3:0] n;
    n[0] = p[3];
    n[1] = p[0] ^ p[3];
    n[2] = p[1];
    n[3] = p[2];
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; ser_in = 1'b0; func_in = 4'h0; golden = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !ser_out && !bist_sel && !sig_clr && !sig_en, "R1 reset idle",
        {3'b0, done, ser_out, bist_sel, sig_clr, sig_en}, 8'h00);
  endtask

  task automatic t_idle_pass();
    logic [3:0] vals [3] = '{4'h9, 4'h6, 4'hF};
    foreach (vals[k]) begin
      func_in = vals[k];
      ser_in  = k[0];
      @(negedge clk);
      chk(cut_in == vals[k] && !bist_sel, "R2 idle passthrough", {4'h0, cut_in}, {4'h0, vals[k]});
      chk(!done && !ser_out, "R8 quiet while idle", {6'h0, done, ser_out}, 8'h00);
    end
  endtask

  task automatic run_bist(input logic [3:0] seed_bits, input bit good, input bit poke,
                          input bit use_ref, input string tag);
    logic [3:0] p;
    logic [3:0] s;
    logic [3:0] e;
    e = (seed_bits == 4'h0) ? 4'h8 : seed_bits;
    s = '0;
    p = e;
    for (int i = 0; i < 15; i++) begin
      s = {s[2:0], s[3]} ^ (p ^ 4'h5);
      p = nstep(p);
    end
    golden  = good ? s : ~s;
    func_in = 4'hA;
    for (int b = 3; b >= 0; b--) begin
      ser_in = seed_bits[b];
      @(negedge clk);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(sig_clr && !bist_sel, {"R3 clear cycle ", tag}, {6'h0, sig_clr, bist_sel}, 8'h02);
    @(negedge clk);
    p = e;
    for (int i = 0; i < 15; i++) begin
      chk(bist_sel && sig_en, {"R6 pattern window ", tag}, {6'h0, bist_sel, sig_en}, 8'h03);
      chk(cut_in == p, {"R5 R4 pattern ", tag}, {4'h0, cut_in}, {4'h0, p});
      if (use_ref) chk(cut_in == ref_seq[i], "R5 listed sequence", {4'h0, cut_in}, {4'h0, ref_seq[i]});
      start = (poke && (i == 5 || i == 6));
      p = nstep(p);
      @(negedge clk);
    end
    start = 1'b0;
    chk(!bist_sel && !done, {"R6 run ends after 15 ", tag}, {6'h0, bist_sel, done}, 8'h00);
    chk(cut_in == func_in, {"R2 compare passthrough ", tag}, {4'h0, cut_in}, {4'h0, func_in});
    @(negedge clk);
    chk(done && ser_out, {"R8 marker ", tag}, {6'h0, done, ser_out}, 8'h03);
    @(negedge clk);
    chk(done && (ser_out == good), {"R7 status bit ", tag}, {6'h0, done, ser_out}, {6'h0, 1'b1, good});
    @(negedge clk);
    chk(!done && !ser_out, {"R8 back to idle ", tag}, {6'h0, done, ser_out}, 8'h00);
    if (poke) chk(!sig_clr && !bist_sel, "R9 start during run ignored", {6'h0, sig_clr, bist_sel}, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_pass();
    run_bist(4'h8, 1'b1, 1'b0, 1'b1, "seed8");
    run_bist(4'h6, 1'b0, 1'b0, 1'b0, "seed6 bad golden");
    run_bist(4'h0, 1'b1, 1'b0, 1'b1, "zero seed");
    run_bist(4'hB, 1'b1, 1'b1, 1'b0, "start poke");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule